// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block steers an on-chip debug session. Once software arms it, the block starts in stage 0. It follows match pulses from a set of address comparators through a programmable graph of four stages. When it reaches the final stage, it asks the CPU for a breakpoint and starts a trace session. A software trigger sends the block straight to the final stage and needs no comparator hit. For each stage and comparator, a configuration field gives the next stage.

Three status inputs shape the result:

- **Background activity.** While the background debug machinery is active, or is doing its own bus accesses, comparator matches are ignored. An armed block stays armed while this happens.
- **Security.** A secured device still gets breakpoints but never gets a trace trigger.
- **Background debug disabled.** A breakpoint cannot enter background mode. Such a request is delivered as a software-interrupt breakpoint instead.

The comparators and the CPU lie outside this block.

Top module: `dbg_seq_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, the stage is 0 (`seq_state_o` = 0), the block is disarmed and the breakpoint and trace outputs are low.
- R2: When the block is disarmed, an `arm_i` pulse sets `armed_o` on the next clock with the stage at 0. While disarmed, comparator matches and the software trigger leave the stage at 0.
- R3: The block is armed, not in stage 3 and not suppressed, and comparator c pulses in stage s. On the next clock the stage takes the 2-bit field `nxt_cfg_i[(s*NUM_CMP+c)*2 +: 2]`. If several comparators match in one cycle, the lowest-numbered one decides.
- R4: Stage 3 is the final stage. It lasts exactly one cycle while armed. On the following clock the stage returns to 0 and `armed_o` clears.
- R5: An armed `sw_trig_i` sends the block to stage 3 on the next clock, whatever the match inputs or suppression status are.
- R6: `disarm_i` returns the block to stage 0 and clears `armed_o` on the next clock. It takes priority over arm, the software trigger and matches.
- R7: In the final-stage cycle with `brk_en_i` high, `brk_use_swi_i` = 0 pulses `brk_bgnd_o` and `brk_use_swi_i` = 1 pulses `brk_swi_o`. With `brk_en_i` low, neither output pulses.
- R8: With `bgnd_en_i` low, `brk_bgnd_o` never rises. An enabled breakpoint is issued on `brk_swi_o` instead.
- R9: With `secure_i` high, `trace_trig_o` stays low while breakpoints are still issued.
- R10: While `bgnd_active_i` or `bgnd_access_i` is high, comparator matches do not change the stage.
- R11: `armed_o` stays set when background mode becomes active.
- R12: When not secure, `trace_trig_o` is high for exactly the final-stage cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm request |
| disarm_i | input | 1 | Disarm request |
| match_i | input | NUM_CMP | Comparator match pulses |
| sw_trig_i | input | 1 | Immediate software trigger |
| nxt_cfg_i | input | 3*NUM_CMP*2 | Next-stage field per non-final stage and comparator |
| brk_en_i | input | 1 | Breakpoint enable |
| brk_use_swi_i | input | 1 | Breakpoint kind: 0 background entry, 1 software interrupt |
| secure_i | input | 1 | Device secured |
| bgnd_en_i | input | 1 | Background debug enabled |
| bgnd_active_i | input | 1 | Background mode active |
| bgnd_access_i | input | 1 | Background hardware access in progress |
| seq_state_o | output | 2 | Current stage |
| armed_o | output | 1 | Armed flag |
| brk_bgnd_o | output | 1 | Breakpoint request entering background mode |
| brk_swi_o | output | 1 | Breakpoint request as software interrupt |
| trace_trig_o | output | 1 | Trace session trigger |

## Verification
The assertions assume the following about the inputs:

- Reset is applied before any other activity.
- Configuration and status inputs stay steady while a session is in progress, so a pulse seen in the final stage reflects the settings of that session.
- Arm and disarm may both be high together; disarm then wins.

The stimulus follows these rules. It changes configuration only between sessions and drives all inputs one time unit after the clock edge. It sweeps every pair of match vectors across several configuration words, and it sweeps every combination of the four gating inputs.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
    localparam int STATE_W     = 2;
    localparam int NUM_STATES  = 1 << STATE_W;
    localparam int NONFINAL    = NUM_STATES - 1;

    typedef enum logic [STATE_W-1:0] {
        SEQ_S0    = 2'd0,
        SEQ_S1    = 2'd1,
        SEQ_S2    = 2'd2,
        SEQ_FINAL = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic brk_bgnd;
        logic brk_swi;
        logic trace;
    } seq_evt_t;

    function automatic int cfg_base(input int stage, input int cmp, input int ncmp);
        return (stage * ncmp + cmp) * STATE_W;
    endfunction
endpackage

// File: rtl/dbg_seq_next.sv
module dbg_seq_next
    import dbg_seq_pkg::*;
#(
    parameter int NUM_CMP = 3,
    localparam int CFG_W  = NONFINAL * NUM_CMP * STATE_W
) (
    input  seq_state_e           cur_i,
    input  logic [NUM_CMP-1:0]   match_i,
    input  logic [CFG_W-1:0]     cfg_i,
    output logic                 hit_o,
    output seq_state_e           nxt_o
);
    logic [STATE_W-1:0] fld [NUM_CMP];
    int                 sidx;

    always_comb sidx = (cur_i == SEQ_FINAL) ? 0 : int'(cur_i);

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_fld
        assign fld[c] = cfg_i[cfg_base(sidx, c, NUM_CMP) +: STATE_W];
    end

    always_comb begin
        nxt_o = cur_i;
        for (int c = NUM_CMP - 1; c >= 0; c--) begin
            if (match_i[c]) nxt_o = seq_state_e'(fld[c]);
        end
        hit_o = |match_i;
    end
endmodule

// File: rtl/dbg_seq_brk.sv
module dbg_seq_brk
    import dbg_seq_pkg::*;
(
    input  logic     fire_i,
    input  logic     brk_en_i,
    input  logic     use_swi_i,
    input  logic     bgnd_en_i,
    input  logic     secure_i,
    output seq_evt_t evt_o
);
    logic want_bgnd;

    always_comb begin
        want_bgnd      = brk_en_i && !use_swi_i;
        evt_o.brk_bgnd = fire_i && want_bgnd && bgnd_en_i;
        evt_o.brk_swi  = fire_i && brk_en_i && (use_swi_i || !bgnd_en_i);
        evt_o.trace    = fire_i && !secure_i;
    end
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
    import dbg_seq_pkg::*;
#(
    parameter int NUM_CMP = 3,
    localparam int CFG_W  = NONFINAL * NUM_CMP * STATE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_i,
    input  logic               disarm_i,
    input  logic [NUM_CMP-1:0] match_i,
    input  logic               sw_trig_i,
    input  logic [CFG_W-1:0]   nxt_cfg_i,
    input  logic               brk_en_i,
    input  logic               brk_use_swi_i,
    input  logic               secure_i,
    input  logic               bgnd_en_i,
    input  logic               bgnd_active_i,
    input  logic               bgnd_access_i,
    output logic [STATE_W-1:0] seq_state_o,
    output logic               armed_o,
    output logic               brk_bgnd_o,
    output logic               brk_swi_o,
    output logic               trace_trig_o
);
    seq_state_e state_q;
    seq_state_e nxt_st;
    logic       armed_q;
    logic       hit;
    logic       suppress;
    logic       fire;
    seq_evt_t   evt;

    dbg_seq_next #(.NUM_CMP(NUM_CMP)) u_next (
        .cur_i   (state_q),
        .match_i (match_i),
        .cfg_i   (nxt_cfg_i),
        .hit_o   (hit),
        .nxt_o   (nxt_st)
    );

    always_comb begin
        suppress = bgnd_active_i || bgnd_access_i;
        fire     = armed_q && (state_q == SEQ_FINAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_S0;
            armed_q <= 1'b0;
        end else if (disarm_i || fire) begin
            state_q <= SEQ_S0;
            armed_q <= 1'b0;
        end else if (!armed_q) begin
            state_q <= SEQ_S0;
            if (arm_i) armed_q <= 1'b1;
        end else if (sw_trig_i) begin
            state_q <= SEQ_FINAL;
        end else if (hit && !suppress) begin
            state_q <= nxt_st;
        end
    end

    dbg_seq_brk u_brk (
        .fire_i    (fire),
        .brk_en_i  (brk_en_i),
        .use_swi_i (brk_use_swi_i),
        .bgnd_en_i (bgnd_en_i),
        .secure_i  (secure_i),
        .evt_o     (evt)
    );

    assign seq_state_o  = state_q;
    assign armed_o      = armed_q;
    assign brk_bgnd_o   = evt.brk_bgnd;
    assign brk_swi_o    = evt.brk_swi;
    assign trace_trig_o = evt.trace;
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       arm_i,
    input logic       disarm_i,
    input logic       sw_trig_i,
    input logic       secure_i,
    input logic       bgnd_en_i,
    input logic       bgnd_active_i,
    input logic       bgnd_access_i,
    input logic       any_match,
    input logic [1:0] seq_state_o,
    input logic       armed_o,
    input logic       brk_bgnd_o,
    input logic       brk_swi_o,
    input logic       trace_trig_o
);
    p_arm_r2: assert property (@(posedge clk) disable iff (rst)
        (!armed_o && arm_i && !disarm_i) |=> (armed_o && seq_state_o == 2'd0));

    p_hold_unarmed_r2: assert property (@(posedge clk) disable iff (rst)
        (!armed_o) |=> (seq_state_o == 2'd0));

    p_final_return_r4: assert property (@(posedge clk) disable iff (rst)
        (armed_o && seq_state_o == 2'd3) |=> (seq_state_o == 2'd0 && !armed_o));

    p_swtrig_r5: assert property (@(posedge clk) disable iff (rst)
        (armed_o && sw_trig_i && !disarm_i && seq_state_o != 2'd3) |=> (seq_state_o == 2'd3));

    p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
        disarm_i |=> (!armed_o && seq_state_o == 2'd0));

    p_brk_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({brk_bgnd_o, brk_swi_o}));

    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (brk_bgnd_o || brk_swi_o) |=> !(brk_bgnd_o || brk_swi_o));

    p_no_bgnd_r8: assert property (@(posedge clk) disable iff (rst)
        !bgnd_en_i |-> !brk_bgnd_o);

    p_secure_r9: assert property (@(posedge clk) disable iff (rst)
        secure_i |-> !trace_trig_o);

    p_suppress_r10: assert property (@(posedge clk) disable iff (rst)
        (armed_o && (bgnd_active_i || bgnd_access_i) && any_match && !sw_trig_i
         && !disarm_i && seq_state_o != 2'd3) |=> $stable(seq_state_o));

    p_keep_armed_r11: assert property (@(posedge clk) disable iff (rst)
        (armed_o && $rose(bgnd_active_i) && !disarm_i && seq_state_o != 2'd3) |=> armed_o);

    p_trace_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        trace_trig_o |=> !trace_trig_o);
endmodule

bind dbg_seq_top dbg_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .arm_i         (arm_i),
    .disarm_i      (disarm_i),
    .sw_trig_i     (sw_trig_i),
    .secure_i      (secure_i),
    .bgnd_en_i     (bgnd_en_i),
    .bgnd_active_i (bgnd_active_i),
    .bgnd_access_i (bgnd_access_i),
    .any_match     (|match_i),
    .seq_state_o   (seq_state_o),
    .armed_o       (armed_o),
    .brk_bgnd_o    (brk_bgnd_o),
    .brk_swi_o     (brk_swi_o),
    .trace_trig_o  (trace_trig_o)
);

// File: tb/dbg_seq_top_tb.sv
module dbg_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCMP       = 3;
    localparam int CW         = 3 * NCMP * 2;

    logic          clk = 1'b0;
    logic          rst, arm, disarm, swtrig, brk_en, use_swi, secure, bgnd_en, bact, bacc;
    logic [NCMP-1:0] match;
    logic [CW-1:0] cfg;
    logic [1:0]    st;
    logic          armed, brk_bgnd, brk_swi, trig;
    int            checks = 0;
    int            errors = 0;
    bit            done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_seq_top #(.NUM_CMP(NCMP)) u_dut (
        .clk(clk), .rst(rst), .arm_i(arm), .disarm_i(disarm), .match_i(match),
        .sw_trig_i(swtrig), .nxt_cfg_i(cfg), .brk_en_i(brk_en), .brk_use_swi_i(use_swi),
        .secure_i(secure), .bgnd_en_i(bgnd_en), .bgnd_active_i(bact), .bgnd_access_i(bacc),
        .seq_state_o(st), .armed_o(armed), .brk_bgnd_o(brk_bgnd), .brk_swi_o(brk_swi),
        .trace_trig_o(trig)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int low_idx(input logic [NCMP-1:0] m);
        for (int i = 0; i < NCMP; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic int fld(input logic [CW-1:0] c, input int s, input int k);
        return int'(c[(s*NCMP+k)*2 +: 2]);
    endfunction

    task automatic idle_chk(input string req);
        chk(req, "state", int'(st), 0);
        chk(req, "armed", int'(armed), 0);
        chk(req, "outputs", int'({brk_bgnd, brk_swi, trig}), 0);
    endtask

    task automatic do_arm;
        arm = 1'b1; tick; arm = 1'b0;
    endtask

    task automatic final_chk(input string req);
        int eb, es;
        eb = int'(brk_en && !use_swi && bgnd_en);
        es = int'(brk_en && (use_swi || !bgnd_en));
        chk(req, "final state", int'(st), 3);
        chk("R7", "brk_bgnd", int'(brk_bgnd), eb);
        chk("R8", "brk_swi", int'(brk_swi), es);
        chk("R12", "trace", int'(trig), int'(!secure));
        tick;
        idle_chk("R4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; arm = 0; disarm = 0; swtrig = 0; match = '0; cfg = '0;
        brk_en = 1; use_swi = 0; secure = 0; bgnd_en = 1; bact = 0; bacc = 0;
        tick; tick;
        idle_chk("R1");
        rst = 1'b0;
        tick;
        idle_chk("R1");

        // R2: disarmed block ignores matches and software trigger
        cfg = '1;
        match = '1; swtrig = 1'b1; tick;
        match = '0; swtrig = 1'b0;
        idle_chk("R2");
        do_arm;
        chk("R2", "armed", int'(armed), 1);
        chk("R2", "state", int'(st), 0);

        // R10/R11: suppressed matches, arming kept in background mode
        bacc = 1'b1; match = 3'b001; tick;
        chk("R10", "state access", int'(st), 0);
        bacc = 1'b0; bact = 1'b1; match = 3'b010; tick;
        chk("R10", "state active", int'(st), 0);
        chk("R11", "armed", int'(armed), 1);
        tick;
        chk("R11", "armed hold", int'(armed), 1);
        bact = 1'b0; match = 3'b001; tick; match = '0;
        final_chk("R3");

        // R5: software trigger wins over suppression and matches
        cfg = '0;
        do_arm;
        bact = 1'b1; swtrig = 1'b1; match = 3'b111; tick;
        bact = 1'b0; swtrig = 1'b0; match = '0;
        final_chk("R5");

        // R6: disarm priority
        do_arm;
        disarm = 1'b1; swtrig = 1'b1; tick;
        disarm = 1'b0; swtrig = 1'b0;
        idle_chk("R6");
        tick;
        idle_chk("R6");

        // R3/R4/R6: sweep of match vector pairs over several configuration words
        for (int seed = 0; seed < 4; seed++) begin
            cfg = CW'((seed + 1) * 32'h2B5E3 ^ 32'h15A3C);
            use_swi = seed[0];
            for (int m1 = 1; m1 < 8; m1++) begin
                for (int m2 = 1; m2 < 8; m2++) begin
                    int e1, e2;
                    do_arm;
                    match = NCMP'(m1); tick; match = '0;
                    e1 = fld(cfg, 0, low_idx(NCMP'(m1)));
                    chk("R3", "first step", int'(st), e1);
                    if (e1 == 3) begin
                        final_chk("R4");
                    end else begin
                        chk("R4", "no trace", int'(trig), 0);
                        match = NCMP'(m2); tick; match = '0;
                        e2 = fld(cfg, e1, low_idx(NCMP'(m2)));
                        chk("R3", "second step", int'(st), e2);
                        if (e2 == 3) begin
                            final_chk("R4");
                        end else begin
                            disarm = 1'b1; tick; disarm = 1'b0;
                            idle_chk("R6");
                        end
                    end
                end
            end
        end

        // R7/R8/R9/R12: every combination of gating inputs
        for (int g = 0; g < 16; g++) begin
            brk_en = g[0]; use_swi = g[1]; bgnd_en = g[2]; secure = g[3];
            do_arm;
            swtrig = 1'b1; tick; swtrig = 1'b0;
            chk("R9", "brk present when secure", int'(brk_bgnd || brk_swi), int'(brk_en));
            final_chk("R7");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule